// File: doc/BRIEF.md
# Split-Phase Register File

This block is the architectural register store of a five-stage in-order integer pipeline. The decode stage looks up two source operands at once through two combinational read ports. In the same cycle, the write-back stage of an older instruction commits its result through a single synchronous write port. When both stages touch the same register in one cycle, the read ports see the value being committed. It behaves as if the write lands early in the cycle and the reads happen late, so the pipeline never has to stall for this case.

Entry zero is a constant zero source. Writes aimed at it are dropped, and it never takes part in the same-cycle forwarding. A synchronous reset clears every entry. The entry count, data width, the constant-zero entry and the forwarding path are all parameters, and elaboration checks reject illegal values.

Top module: `split_phase_regfile`

## Requirements
- R1: In the cycle after a synchronous reset (`rst` high at a rising edge), every register reads as zero on both read ports.
- R2: A write with `wr_en` high to a non-zero address `wr_addr` at a rising edge stores `wr_data`. From the next cycle on, that register reads back `wr_data` on either read port until it is written again.
- R3: Reading address 0 on either port always returns zero.
- R4: A write to address 0 changes nothing. It is not forwarded in the same cycle and does not alter entry 0 or any other register.
- R5: When `wr_en` is high and `wr_addr` is non-zero and equal to a read address, that read port returns `wr_data` in the same cycle, before the edge that commits it.
- R6: When `wr_en` is low, a read whose address equals `wr_addr` returns the stored value, not `wr_data`.
- R7: The two read ports are independent. Each returns the register selected by its own address, including when both select the same register.
- R8: A write alters only the addressed register, and every other register keeps its value.
- R9: With `wr_en` low, a rising edge leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Commit enable from write-back |
| wr_addr | input | 5 | Destination register index |
| wr_data | input | 32 | Value to commit |
| rd_addr_a | input | 5 | First source register index |
| rd_data_a | output | 32 | First source operand |
| rd_addr_b | input | 5 | Second source register index |
| rd_data_b | output | 32 | Second source operand |

## Verification
The hard case is the window in the middle of a cycle in which a write is presented but not yet committed. There, the read ports must already show the new value, while the stored copy still holds the old one. The bench drives the write and both read addresses together at the falling edge and samples the read data before the next rising edge. For every non-zero register it points one port at the target and the other at an untouched register, and then at the target as well. It repeats the same window with the enable low and with address 0 to show that no forwarding happens in those cases.

// File: rtl/rf_pkg.sv
package rf_pkg;

   localparam int unsigned RF_DEF_WIDTH   = 32;
   localparam int unsigned RF_DEF_ENTRIES = 32;

   // Returns 1 when a pending commit must be forwarded to a read of rd_idx.
   function automatic logic fwd_hit(input logic        en,
                                    input int unsigned w_idx,
                                    input int unsigned rd_idx,
                                    input logic        zero_pinned);
      logic hit;
      hit = en && (w_idx == rd_idx);
      if (zero_pinned && (w_idx == 0)) hit = 1'b0;
      return hit;
   endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
   parameter int unsigned ENTRIES   = 32,
   parameter bit          ZERO_REG  = 1'b1,
   localparam int unsigned AW       = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   output logic [ENTRIES-1:0] wr_sel
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
      if (ZERO_REG && (e == 0)) begin : g_pinned
         assign wr_sel[e] = 1'b0;
      end else begin : g_live
         assign wr_sel[e] = wr_en && (wr_addr == AW'(e));
      end
   end

   // R8: at most one entry is selected by any commit
   a_r8_single_target: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_sel));

   // R9: no entry is selected without the enable
   a_r9_idle_no_select: assert property (@(posedge clk) disable iff (rst)
      !wr_en |-> (wr_sel == '0));

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned ENTRIES  = 32,
   parameter bit          ZERO_REG = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [ENTRIES-1:0]              wr_sel,
   input  logic [WIDTH-1:0]                wr_data,
   output logic [ENTRIES-1:0][WIDTH-1:0]   regs_q
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      if (ZERO_REG && (e == 0)) begin : g_const
         assign regs_q[e] = '0;
      end else begin : g_flop
         logic [WIDTH-1:0] val_q;
         always_ff @(posedge clk) begin
            if (rst)            val_q <= '0;
            else if (wr_sel[e]) val_q <= wr_data;
         end
         assign regs_q[e] = val_q;
      end
   end

   // R4: entry 0 never leaves zero when pinned
   if (ZERO_REG) begin : g_zero_chk
      a_r4_entry0_zero: assert property (@(posedge clk) disable iff (rst)
         regs_q[0] == '0);
   end

   // R9: an edge with nothing selected changes no entry
   a_r9_hold_state: assert property (@(posedge clk) disable iff (rst)
      (wr_sel == '0) |=> $stable(regs_q));

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
   import rf_pkg::*;
#(
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned ENTRIES  = 32,
   parameter bit          ZERO_REG = 1'b1,
   parameter bit          FORWARD  = 1'b1,
   localparam int unsigned AW      = $clog2(ENTRIES)
) (
   input  logic [AW-1:0]                   rd_addr,
   input  logic [ENTRIES-1:0][WIDTH-1:0]   regs_q,
   input  logic                            wr_en,
   input  logic [AW-1:0]                   wr_addr,
   input  logic [WIDTH-1:0]                wr_data,
   output logic [WIDTH-1:0]                rd_data
);

   logic [WIDTH-1:0] stored;
   assign stored = regs_q[rd_addr];

   if (FORWARD) begin : g_fwd
      logic hit;
      always_comb begin
         hit     = fwd_hit(wr_en, int'(wr_addr), int'(rd_addr), ZERO_REG);
         rd_data = hit ? wr_data : stored;
      end
   end else begin : g_plain
      assign rd_data = stored;
   end

endmodule

// File: rtl/split_phase_regfile.sv
module split_phase_regfile
   import rf_pkg::*;
#(
   parameter int unsigned WIDTH    = RF_DEF_WIDTH,
   parameter int unsigned ENTRIES  = RF_DEF_ENTRIES,
   parameter bit          ZERO_REG = 1'b1,
   parameter bit          FORWARD  = 1'b1,
   localparam int unsigned AW      = $clog2(ENTRIES),
   localparam int unsigned NRD     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr_a,
   output logic [WIDTH-1:0] rd_data_a,
   input  logic [AW-1:0]    rd_addr_b,
   output logic [WIDTH-1:0] rd_data_b
);

   initial begin
      if (WIDTH < 1)              $error("WIDTH must be at least 1");
      if (ENTRIES < 2)            $error("ENTRIES must be at least 2");
      if ((1 << AW) != ENTRIES)   $error("ENTRIES must be a power of two");
   end

   logic [ENTRIES-1:0]            wr_sel;
   logic [ENTRIES-1:0][WIDTH-1:0] regs_q;
   logic [NRD-1:0][AW-1:0]        rd_addr_v;
   logic [NRD-1:0][WIDTH-1:0]     rd_data_v;

   assign rd_addr_v[0] = rd_addr_a;
   assign rd_addr_v[1] = rd_addr_b;
   assign rd_data_a    = rd_data_v[0];
   assign rd_data_b    = rd_data_v[1];

   rf_wr_decode #(.ENTRIES(ENTRIES), .ZERO_REG(ZERO_REG)) u_dec (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel));

   rf_storage #(.WIDTH(WIDTH), .ENTRIES(ENTRIES), .ZERO_REG(ZERO_REG)) u_store (
      .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_data(wr_data), .regs_q(regs_q));

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      rf_read_port #(.WIDTH(WIDTH), .ENTRIES(ENTRIES), .ZERO_REG(ZERO_REG),
                     .FORWARD(FORWARD)) u_port (
         .rd_addr(rd_addr_v[p]), .regs_q(regs_q), .wr_en(wr_en),
         .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data_v[p]));
   end

   // R2: a committed non-zero write is held by the storage next cycle
   a_r2_commit_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_addr != '0)) |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

   // R1: reset leaves storage all zero
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (regs_q == '0));

   if (ZERO_REG) begin : g_zero_ports
      // R3: address zero reads zero on both ports
      a_r3_zero_port_a: assert property (@(posedge clk) disable iff (rst)
         (rd_addr_a == '0) |-> (rd_data_a == '0));
      a_r3_zero_port_b: assert property (@(posedge clk) disable iff (rst)
         (rd_addr_b == '0) |-> (rd_data_b == '0));
   end

   if (FORWARD) begin : g_fwd_chk
      // R5: a pending commit is visible on a matching read port
      a_r5_forward_a: assert property (@(posedge clk) disable iff (rst)
         (wr_en && (wr_addr != '0) && (wr_addr == rd_addr_a)) |-> (rd_data_a == wr_data));
      a_r5_forward_b: assert property (@(posedge clk) disable iff (rst)
         (wr_en && (wr_addr != '0) && (wr_addr == rd_addr_b)) |-> (rd_data_b == wr_data));
   end

   // R7: equal addresses on both ports give equal data
   a_r7_ports_agree: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

endmodule

// File: tb/tb_split_phase_regfile.sv
`timescale 1ns/1ps
module tb_split_phase_regfile;

   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [4:0]  wr_addr, rd_addr_a, rd_addr_b;
   logic [31:0] wr_data;
   logic [31:0] rd_data_a, rd_data_b;

   logic [31:0] model [N];
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;

   always #5 clk = ~clk;

   split_phase_regfile dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pattern(input int r, input int pass);
      return (32'h9E3779B9 * (r + 1)) ^ (32'h01010101 * pass) ^ {27'd0, 5'(r)};
   endfunction

   // Sweep every register on both ports, port b walking in reverse.
   task automatic sweep(input string req);
      @(negedge clk);
      wr_en = 1'b0;
      for (int r = 0; r < N; r++) begin
         rd_addr_a = 5'(r);
         rd_addr_b = 5'(N - 1 - r);
         #0.5;
         check(req, rd_data_a, model[r]);
         check(req, rd_data_b, model[N - 1 - r]);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      rd_addr_a = '0; rd_addr_b = '0;
      for (int r = 0; r < N; r++) model[r] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1: everything zero after reset
      sweep("R1");

      for (int pass = 0; pass < 2; pass++) begin
         for (int r = 1; r < N; r++) begin
            int other;
            other = (r == N - 1) ? 1 : r + 1;
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(r); wr_data = pattern(r, pass);
            rd_addr_a = 5'(r); rd_addr_b = 5'(other);
            #0.5;
            check("R5", rd_data_a, pattern(r, pass));     // forwarded value
            check("R7", rd_data_b, model[other]);        // neighbour untouched
            rd_addr_b = 5'(r);
            #0.5;
            check("R5", rd_data_b, pattern(r, pass));
            @(posedge clk);
            model[r] = pattern(r, pass);
            @(negedge clk);
            wr_en = 1'b0;
            rd_addr_a = 5'(other); rd_addr_b = 5'(r);
            #0.5;
            check("R2", rd_data_b, model[r]);
            check("R8", rd_data_a, model[other]);
         end
         sweep("R2");
      end

      // R4 / R3: writes to address 0 are neither forwarded nor stored
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = '0; wr_data = 32'hDEAD0000 | k;
         rd_addr_a = '0; rd_addr_b = '0;
         #0.5;
         check("R4", rd_data_a, 32'd0);
         check("R3", rd_data_b, 32'd0);
         @(posedge clk);
      end
      sweep("R4");

      // R6 / R9: matching address with the enable low
      for (int r = 1; r < N; r++) begin
         @(negedge clk);
         wr_en = 1'b0; wr_addr = 5'(r); wr_data = ~model[r];
         rd_addr_a = 5'(r); rd_addr_b = 5'(r);
         #0.5;
         check("R6", rd_data_a, model[r]);
         check("R6", rd_data_b, model[r]);
         @(posedge clk);
      end
      sweep("R9");

      // R1: reset again after state is populated
      @(negedge clk); rst = 1'b1;
      @(posedge clk);
      @(negedge clk); rst = 1'b0;
      for (int r = 0; r < N; r++) model[r] = '0;
      sweep("R1");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule